// File: doc/BRIEF.md
# Dual-Panel Fetch Sequencer

This block decides which of two memory-fetch channels of a display controller asks the system bus for the next burst, and at which address. Channel 1 always starts a frame by reading the colour lookup table from the front of the upper frame buffer. It then continues with upper-panel pixels. When the controller drives a split screen, channel 2 fetches the lower-panel pixels from its own base address. After the lookup table is loaded, the two channels take turns, and each feeds its own pixel FIFO. When the controller drives a single screen, only channel 1 runs.

Software writes the mode bit and both base addresses while the block is disabled, and then raises the enable. The block copies the mode and the bases at every frame start. A request stays on the bus until it is granted. One cycle after the grant, a write strobe tells the palette RAM or the matching FIFO that a burst has landed. If the enable is cleared in the middle of a frame, the block finishes that frame and then stops.

Top module: `lcd_panel_fetch_seq`

## Requirements
- R1: After reset, `req`, `pal_wr`, `up_wr` and `lo_wr` are low, and no request is issued while `enable` stays low.
- R2: Each frame begins with PAL_WORDS/BURST requests with `tag`=0 (0 means channel 1) at `base_upper` + k*BURST, where k = 0, 1, 2 and so on. Each of these requests is followed by a `pal_wr` strobe.
- R3: After the palette bursts, channel 1 makes PIX_WORDS/BURST further requests that continue upward from `base_upper` + PAL_WORDS in steps of BURST. Each is followed by an `up_wr` strobe.
- R4: When `dual_mode` was 0 at frame start, every request of that frame carries `tag`=0.
- R5: When `dual_mode` was 1 at frame start, channel 2 (`tag`=1) makes PIX_WORDS/BURST requests at `base_lower` + k*BURST, each followed by `lo_wr`. When both channels may fetch, they strictly alternate, and the upper channel goes first after the palette.
- R6: Channel 2 issues no request while the palette load of the current frame is unfinished.
- R7: A pixel channel whose almost-full flag was high at the deciding edge yields its turn to the other channel. Alternation resumes once the flag drops. With both flags high, no request is made. The palette load ignores `fifo_afull_up`.
- R8: Once `req` is raised, `req`, `addr` and `tag` stay unchanged until `grant` is sampled high.
- R9: Exactly one write strobe pulses, in the cycle after each granted request, and no strobe pulses at any other time.
- R10: When a frame's last burst is granted and `enable` is high, a new frame starts again with the palette at `base_upper`.
- R11: When `enable` is cleared during a frame, the remaining requests of that frame are still issued, and after that no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request; sampled at frame boundaries |
| dual_mode | input | 1 | 1 = split screen with two channels; latched at frame start |
| base_upper | input | AW | Upper frame buffer base (palette, then upper pixels) |
| base_lower | input | AW | Lower frame buffer base |
| fifo_afull_up | input | 1 | Upper pixel FIFO almost full |
| fifo_afull_lo | input | 1 | Lower pixel FIFO almost full |
| grant | input | 1 | Bus accepts the pending request |
| req | output | 1 | Burst request |
| addr | output | AW | Word address of the requested burst |
| tag | output | 1 | Requesting channel: 0 = channel 1, 1 = channel 2 |
| pal_wr | output | 1 | Palette burst written |
| up_wr | output | 1 | Upper FIFO burst written |
| lo_wr | output | 1 | Lower FIFO burst written |

## Verification
The embedded properties check the following on every cycle:
- a pending request stays stable until it is granted;
- strobes are single and tied to a grant;
- channel 2 stays silent during the palette and in single mode;
- no pixel channel is chosen while its FIFO reported almost full.

Only the directed scenarios can show the ordering and address arithmetic of a whole frame, strict alternation, and the restart at the bases on frame wrap. They also cover the drain of the current frame after the enable drops and the switch to the other channel when a FIFO fills. The bench compares each of these against its own model of the turn-taking rule.

// File: rtl/pfa_pkg.sv
package pfa_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } run_st_t;

   typedef enum logic {
      CH_UPPER = 1'b0,
      CH_LOWER = 1'b1
   } chan_t;
endpackage

// File: rtl/pfa_chan_ctr.sv
module pfa_chan_ctr #(
   parameter int AW    = 16,
   parameter int CW    = 4,
   parameter int STEP  = 4,
   parameter int LIMIT = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic          adv,
   output logic [AW-1:0] addr,
   output logic [CW-1:0] count
);
   initial begin
      assert (LIMIT > 0 && LIMIT < (1 << CW) && STEP > 0)
         else $error("pfa_chan_ctr: LIMIT or STEP out of range");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr  <= '0;
         count <= '0;
      end else if (load) begin
         addr  <= base;
         count <= '0;
      end else if (adv && count != CW'(LIMIT)) begin
         addr  <= addr + AW'(STEP);
         count <= count + CW'(1);
      end
   end

   // R3 / R5: a channel never runs past its per-frame burst count
   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(LIMIT));
endmodule

// File: rtl/pfa_turn_pick.sv
module pfa_turn_pick (
   input  logic turn_lo,
   input  logic want_up,
   input  logic want_lo,
   output logic go,
   output logic pick_lo
);
   always_comb begin
      go = want_up | want_lo;
      if (want_up && want_lo) pick_lo = turn_lo;
      else                    pick_lo = want_lo;
   end
endmodule

// File: rtl/lcd_panel_fetch_seq.sv
module lcd_panel_fetch_seq
   import pfa_pkg::*;
#(
   parameter int AW        = 16,
   parameter int BURST     = 4,
   parameter int PAL_WORDS = 16,
   parameter int PIX_WORDS = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          dual_mode,
   input  logic [AW-1:0] base_upper,
   input  logic [AW-1:0] base_lower,
   input  logic          fifo_afull_up,
   input  logic          fifo_afull_lo,
   input  logic          grant,
   output logic          req,
   output logic [AW-1:0] addr,
   output logic          tag,
   output logic          pal_wr,
   output logic          up_wr,
   output logic          lo_wr
);
   localparam int PAL_BURSTS = PAL_WORDS / BURST;
   localparam int PIX_BURSTS = PIX_WORDS / BURST;
   localparam int UP_BURSTS  = PAL_BURSTS + PIX_BURSTS;
   localparam int CW         = $clog2(UP_BURSTS + 1);

   initial begin
      assert (BURST > 0 && PAL_WORDS > 0 && PIX_WORDS > 0 &&
              PAL_WORDS % BURST == 0 && PIX_WORDS % BURST == 0)
         else $error("lcd_panel_fetch_seq: word counts must be whole bursts");
   end

   run_st_t      st;
   logic         dual_q, turn_lo, req_q, pal_wr_q, up_wr_q, lo_wr_q;
   chan_t        tag_q;
   logic [AW-1:0] ch_addr [2];
   logic [CW-1:0] ch_cnt  [2];
   logic         pal_phase, up_done, lo_done, frame_done;
   logic         want_up, want_lo, go, pick_lo, hs, start;

   assign pal_phase  = ch_cnt[0] < CW'(PAL_BURSTS);
   assign up_done    = ch_cnt[0] == CW'(UP_BURSTS);
   assign lo_done    = ch_cnt[1] == CW'(PIX_BURSTS);
   assign frame_done = up_done && (lo_done || !dual_q);
   assign want_up    = !up_done && (pal_phase || !fifo_afull_up);
   assign want_lo    = dual_q && !pal_phase && !lo_done && !fifo_afull_lo;
   assign hs         = req_q && grant;
   assign start      = enable && ((st == ST_IDLE) ||
                                  (st == ST_RUN && !req_q && frame_done));

   generate
      for (genvar c = 0; c < 2; c++) begin : g_ch
         localparam int LIM = (c == 0) ? UP_BURSTS : PIX_BURSTS;
         logic [AW-1:0] ch_base;
         logic          ch_adv;
         if (c == 0) begin : g_up
            assign ch_base = base_upper;
            assign ch_adv  = hs && (tag_q == CH_UPPER);
         end else begin : g_lo
            assign ch_base = base_lower;
            assign ch_adv  = hs && (tag_q == CH_LOWER);
         end
         pfa_chan_ctr #(.AW(AW), .CW(CW), .STEP(BURST), .LIMIT(LIM)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (start),
            .base  (ch_base),
            .adv   (ch_adv),
            .addr  (ch_addr[c]),
            .count (ch_cnt[c])
         );
      end
   endgenerate

   pfa_turn_pick u_pick (
      .turn_lo (turn_lo),
      .want_up (want_up),
      .want_lo (want_lo),
      .go      (go),
      .pick_lo (pick_lo)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         dual_q   <= 1'b0;
         turn_lo  <= 1'b0;
         req_q    <= 1'b0;
         tag_q    <= CH_UPPER;
         pal_wr_q <= 1'b0;
         up_wr_q  <= 1'b0;
         lo_wr_q  <= 1'b0;
      end else begin
         pal_wr_q <= 1'b0;
         up_wr_q  <= 1'b0;
         lo_wr_q  <= 1'b0;
         if (start) begin
            st      <= ST_RUN;
            dual_q  <= dual_mode;
            turn_lo <= 1'b0;
         end else if (st == ST_RUN) begin
            if (req_q) begin
               if (grant) begin
                  req_q <= 1'b0;
                  if (tag_q == CH_LOWER) begin
                     lo_wr_q <= 1'b1;
                     turn_lo <= 1'b0;
                  end else if (pal_phase) begin
                     pal_wr_q <= 1'b1;
                  end else begin
                     up_wr_q <= 1'b1;
                     turn_lo <= 1'b1;
                  end
               end
            end else if (frame_done) begin
               st <= ST_IDLE;
            end else if (go) begin
               req_q <= 1'b1;
               tag_q <= pick_lo ? CH_LOWER : CH_UPPER;
            end
         end
      end
   end

   assign req    = req_q;
   assign tag    = tag_q;
   assign addr   = (tag_q == CH_LOWER) ? ch_addr[1] : ch_addr[0];
   assign pal_wr = pal_wr_q;
   assign up_wr  = up_wr_q;
   assign lo_wr  = lo_wr_q;

   // R8: pending request is frozen until granted
   a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      req && !grant |=> req && $stable(addr) && $stable(tag));
   // R9: at most one strobe, and only right after a grant
   a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pal_wr, up_wr, lo_wr}));
   a_r9_strobe_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (pal_wr || up_wr || lo_wr) |-> $past(req && grant));
   // R6: lower channel silent during the palette
   a_r6_lower_after_palette: assert property (@(posedge clk) disable iff (!rst_n)
      req && tag |-> !pal_phase);
   // R4: single mode uses channel 1 only
   a_r4_single_upper_only: assert property (@(posedge clk) disable iff (!rst_n)
      req && !dual_q |-> !tag);
   // R7: a channel with a full FIFO is not chosen
   a_r7_lower_space: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) && tag |-> !$past(fifo_afull_lo));
   a_r7_upper_space: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) && !tag && !pal_phase |-> !$past(fifo_afull_up));
endmodule

// File: tb/sim_lcd_panel_fetch_seq.sv
module sim_lcd_panel_fetch_seq;
   localparam int CLK_P = 10;
   localparam int AW = 16, BURST = 4, PAL_WORDS = 16, PIX_WORDS = 32;
   localparam int PAL_B = PAL_WORDS / BURST;
   localparam int PIX_B = PIX_WORDS / BURST;
   localparam int UP_B  = PAL_B + PIX_B;

   logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, dual_mode = 1'b0;
   logic [AW-1:0] base_upper = '0, base_lower = '0;
   logic fifo_afull_up = 1'b0, fifo_afull_lo = 1'b0, grant = 1'b0;
   logic req, tag, pal_wr, up_wr, lo_wr;
   logic [AW-1:0] addr;

   int tests = 0, fails = 0;
   bit finished = 1'b0;
   int m_up, m_lo, m_dual;
   bit m_turn;

   always #(CLK_P/2) clk = ~clk;

   lcd_panel_fetch_seq #(.AW(AW), .BURST(BURST), .PAL_WORDS(PAL_WORDS),
                         .PIX_WORDS(PIX_WORDS)) u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .dual_mode(dual_mode),
      .base_upper(base_upper), .base_lower(base_lower),
      .fifo_afull_up(fifo_afull_up), .fifo_afull_lo(fifo_afull_lo),
      .grant(grant), .req(req), .addr(addr), .tag(tag),
      .pal_wr(pal_wr), .up_wr(up_wr), .lo_wr(lo_wr));

   task automatic check(input bit ok, input string what, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_up = 0; m_lo = 0; m_turn = 1'b0; m_dual = int'(dual_mode);
   endtask

   function automatic int left_in_frame();
      return (UP_B - m_up) + (m_dual != 0 ? PIX_B - m_lo : 0);
   endfunction

   // Wait for a request, compare it with the model, grant it, check the strobe.
   task automatic serve_one(input int gdly, input bit afu_n, input bit afl_n);
      int w = 0;
      bit pal, eu, el, pick;
      int exp_addr;
      string lbl;
      while (!req && w < 60) begin @(negedge clk); w++; end
      if (!req) begin
         check(1'b0, "R8 request expected but absent", 0, 1);
         return;
      end
      pal = (m_up < PAL_B);
      eu = (m_up < UP_B) && (pal || !fifo_afull_up);
      el = (m_dual != 0) && !pal && (m_lo < PIX_B) && !fifo_afull_lo;
      pick = (eu && el) ? m_turn : el;
      exp_addr = pick ? int'(base_lower) + m_lo * BURST : int'(base_upper) + m_up * BURST;
      lbl = pick ? "R5 lower" : (pal ? "R2 palette R6" : "R3 upper");
      check(tag == pick, {lbl, " tag"}, tag, pick);
      check(int'(addr) == exp_addr, {lbl, " addr"}, addr, exp_addr);
      if (m_dual == 0) check(tag == 1'b0, "R4 single tag", tag, 0);
      for (int d = 0; d < gdly; d++) begin
         @(negedge clk);
         check(req && tag == pick && int'(addr) == exp_addr, "R8 hold", addr, exp_addr);
      end
      grant = 1'b1; fifo_afull_up = afu_n; fifo_afull_lo = afl_n;
      @(negedge clk);
      grant = 1'b0;
      check({pal_wr, up_wr, lo_wr} == {!pick && pal, !pick && !pal, pick},
            "R9 strobe", {pal_wr, up_wr, lo_wr}, {!pick && pal, !pick && !pal, pick});
      if (pick) begin m_lo++; m_turn = 1'b0; end
      else begin m_up++; if (!pal) m_turn = 1'b1; end
      if (left_in_frame() == 0) model_reset();
   endtask

   task automatic serve_n(input int n, input int gdly, input bit afu, input bit afl);
      for (int i = 0; i < n; i++) serve_one(gdly, afu, afl);
   endtask

   task automatic check_idle(input int n, input string lbl);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check(!req && !pal_wr && !up_wr && !lo_wr, lbl, {req, pal_wr, up_wr, lo_wr}, 0);
      end
   endtask

   task automatic t_reset();
      check(!req && !pal_wr && !up_wr && !lo_wr, "R1 reset outputs",
            {req, pal_wr, up_wr, lo_wr}, 0);
      check_idle(10, "R1 idle while disabled");
   endtask

   task automatic t_single();
      dual_mode = 1'b0; base_upper = 16'h1000; base_lower = 16'h8000;
      model_reset(); enable = 1'b1;
      serve_n(UP_B, 0, 1'b0, 1'b0);
      check(m_up == 0, "R10 model wrapped", m_up, 0);
      serve_n(2, 0, 1'b0, 1'b0);          // R10: new frame restarts with palette
      enable = 1'b0;
      serve_n(left_in_frame(), 0, 1'b0, 1'b0);   // R11: drain
      check_idle(30, "R11 stopped after frame");
   endtask

   task automatic t_dual();
      dual_mode = 1'b1; base_upper = 16'h2000; base_lower = 16'h4100;
      model_reset(); enable = 1'b1;
      serve_n(15, 0, 1'b0, 1'b0);
      enable = 1'b0;
      serve_n(left_in_frame(), 1, 1'b0, 1'b0);
      check_idle(20, "R11 dual stopped");
   endtask

   task automatic t_afull();
      dual_mode = 1'b1; base_upper = 16'h0300; base_lower = 16'h0A00;
      fifo_afull_up = 1'b1; model_reset(); enable = 1'b1;
      serve_n(PAL_B, 0, 1'b1, 1'b0);      // R7: palette ignores upper almost-full
      serve_n(3, 0, 1'b1, 1'b0);          // R7: lower only
      serve_n(1, 0, 1'b1, 1'b1);
      check_idle(10, "R7 both full no request");
      fifo_afull_up = 1'b0; fifo_afull_lo = 1'b0;
      enable = 1'b0;
      serve_n(left_in_frame(), 0, 1'b0, 1'b0);
      check_idle(15, "R11 afull stopped");
   endtask

   task automatic t_hold();
      dual_mode = 1'b1; base_upper = 16'h5000; base_lower = 16'h6004;
      model_reset(); enable = 1'b1;
      serve_n(PAL_B + 3, 3, 1'b0, 1'b0);   // R8 delayed grants
      enable = 1'b0;
      serve_n(left_in_frame(), 0, 1'b0, 1'b0);
      check_idle(10, "R11 hold stopped");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_dual();
      t_afull();
      t_hold();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      #(CLK_P * 200000);
      if (!finished) begin
         finished = 1'b1;
         tests++; fails++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule